// File: doc/BRIEF.md
# Packet Modem Control and Status Register Bank

This block is the software-facing control point of a packet modem. An AXI4-Lite slave port lets a host change tuning and mode settings for the modem datapath. It drives those settings out as plain levels: the carrier-loop bandwidth, the inverse equalizer step, the IQ scope tap select, the detector threshold, and the flags for equalizer bypass, header processing, loopback and coding bypass.

The host reads back the byte length of the most recent payload, which comes from the receiver. It can also read one debug quantity through a selectable multiplexer. Lock indications are returned as live levels. Event pulses from the datapath (correlation peaks, header failures, CRC errors and good packets) are counted in saturating counters, and the multiplexer returns the count.

Transmission is controlled in two ways. Flipping a trigger bit launches a single packet. A level bit keeps the packet generator running without gaps.

Top module: `modem_ctrl_regs`

## Requirements
- R1: After reset, every writable field is zero except the equalizer step (reset 64) and the header-processing enable (reset 1). Reads of those registers return these values, and `tx_one_o` is low.
- R2: Writable fields sit at byte offsets 0x100 (loop bandwidth, 32 bits), 0x104 (equalizer 1/mu, 16 bits), 0x108 (scope select, 3 bits), 0x10C (debug select, 3 bits), 0x114 (equalizer bypass, bit 0), 0x118 (header enable, bit 0), 0x11C (detector threshold, 16 bits), 0x12C (loopback, bit 0) and 0x130 (coding bypass, bit 0). Each reads back its written value, truncated to its width and zero-extended, and appears on its output port.
- R3: Offset 0x110 reads `payload_len_i`. Writes to it change nothing.
- R4: Reads of unmapped offsets return zero. Writes to unmapped offsets complete and change no register.
- R5: At offset 0x120, a write with byte lane 0 enabled whose bit 0 differs from the stored bit raises `tx_one_o` for exactly one cycle, the cycle after the write is accepted. A write of the same bit value gives no pulse. The stored bit reads back at 0x120.
- R6: Bit 0 at offset 0x124 drives `tx_cont_o` as a level.
- R7: `det_thr_scaled_o` equals the stored detector threshold divided by 10, rounded down.
- R8: Offset 0x140 returns the source chosen by the debug select code: 0 timing lock level, 1 frequency lock level, 2 peak count, 3 header-failure count, 4 CRC-error count, 5 good-packet count. Codes 6 and 7 return zero.
- R9: Each event input adds one to its 16-bit counter for every cycle it is high, and the counter holds at 0xFFFF.
- R10: Only the byte lanes enabled by `wstrb_i` update a register.
- R11: A write completes with response OKAY (0), and so does a read. Once `bvalid_o` or `rvalid_o` is raised, it holds with stable data until the host accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | ADDR_W | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte lanes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | ADDR_W | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| timing_lock_i | input | 1 | Timing loop lock level |
| freq_lock_i | input | 1 | Frequency loop lock level |
| peak_evt_i | input | 1 | Correlation peak event |
| hdr_fail_evt_i | input | 1 | Header check failure event |
| crc_err_evt_i | input | 1 | CRC error event |
| pkt_ok_evt_i | input | 1 | Good packet event |
| payload_len_i | input | LEN_W | Last payload length in bytes |
| loop_bw_o | output | FBW_W | Carrier-loop bandwidth |
| eq_step_inv_o | output | EQ_W | Equalizer step as 1/mu |
| scope_sel_o | output | SEL_W | IQ scope tap select |
| eq_bypass_o | output | 1 | Equalizer bypass |
| hdr_en_o | output | 1 | Header processing enable |
| det_thr_o | output | THR_W | Detector threshold as written |
| det_thr_scaled_o | output | THR_W | Detector threshold divided by 10 |
| tx_one_o | output | 1 | Single-packet launch pulse |
| tx_cont_o | output | 1 | Continuous transmit enable |
| loopback_o | output | 1 | Internal loopback enable |
| coding_bypass_o | output | 1 | Channel coding bypass |

## Verification
The hardest state to reach is a saturated event counter. It takes more than 65,535 event cycles, and the only way to observe it is through the debug multiplexer. The bench holds the peak input high for 65,540 cycles and then selects that source. It also checks that the neighbouring counters kept their own small counts. The single-cycle launch pulse is sampled in the cycle right after the write is accepted and again one cycle later. This is done for a real bit change, for a rewrite of the same value, and for a write that changes only bit 1.

// File: rtl/modem_ctrl_pkg.sv
package modem_ctrl_pkg;
  localparam logic [11:0] OFF_LOOP_BW  = 12'h100;
  localparam logic [11:0] OFF_EQ_STEP  = 12'h104;
  localparam logic [11:0] OFF_SCOPE    = 12'h108;
  localparam logic [11:0] OFF_DBG_SEL  = 12'h10C;
  localparam logic [11:0] OFF_PLEN     = 12'h110;
  localparam logic [11:0] OFF_EQ_BYP   = 12'h114;
  localparam logic [11:0] OFF_HDR_EN   = 12'h118;
  localparam logic [11:0] OFF_DET_THR  = 12'h11C;
  localparam logic [11:0] OFF_TX_TGL   = 12'h120;
  localparam logic [11:0] OFF_TX_CONT  = 12'h124;
  localparam logic [11:0] OFF_LOOPBACK = 12'h12C;
  localparam logic [11:0] OFF_COD_BYP  = 12'h130;
  localparam logic [11:0] OFF_DBG_VAL  = 12'h140;

  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned EVT_PEAK = 0;
  localparam int unsigned EVT_HDRF = 1;
  localparam int unsigned EVT_CRC  = 2;
  localparam int unsigned EVT_PKT  = 3;

  typedef enum logic [2:0] {
    DBG_TLOCK = 3'd0,
    DBG_FLOCK = 3'd1,
    DBG_PEAK  = 3'd2,
    DBG_HDRF  = 3'd3,
    DBG_CRC   = 3'd4,
    DBG_PKT   = 3'd5
  } dbg_src_e;
endpackage

// File: rtl/modem_axil_if.sv
module modem_axil_if #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_strb_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i
);
  logic bvalid_q, rvalid_q;
  logic [31:0] rdata_q;
  logic wr_acc, rd_acc;

  // address and data are taken together; one write outstanding
  assign wr_acc    = awvalid_i && wvalid_i && !bvalid_q;
  assign rd_acc    = arvalid_i && !rvalid_q;
  assign awready_o = wr_acc;
  assign wready_o  = wr_acc;
  assign arready_o = !rvalid_q;

  assign wr_en_o   = wr_acc;
  assign wr_addr_o = awaddr_i;
  assign wr_data_o = wdata_i;
  assign wr_strb_o = wstrb_i;
  assign rd_addr_o = araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_acc)        bvalid_q <= 1'b1;
      else if (bready_i) bvalid_q <= 1'b0;
      if (rd_acc) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_data_i;
      end else if (rready_i) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid_o = bvalid_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign bresp_o  = 2'b00;
  assign rresp_o  = 2'b00;

  assert_b_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o);
  assert_r_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));
endmodule

// File: rtl/modem_evt_cnt.sv
module modem_evt_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (evt_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == CNT_MAX |=> cnt_o == CNT_MAX);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cnt_o));
endmodule

// File: rtl/modem_dbg_mux.sv
module modem_dbg_mux
  import modem_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                           tlock_i,
  input  logic                           flock_i,
  input  logic [NUM_EVT-1:0][CNT_W-1:0]  cnt_i,
  input  logic [2:0]                     sel_i,
  output logic [CNT_W-1:0]               val_o
);
  always_comb begin
    unique case (sel_i)
      DBG_TLOCK: val_o = CNT_W'(tlock_i);
      DBG_FLOCK: val_o = CNT_W'(flock_i);
      DBG_PEAK:  val_o = cnt_i[EVT_PEAK];
      DBG_HDRF:  val_o = cnt_i[EVT_HDRF];
      DBG_CRC:   val_o = cnt_i[EVT_CRC];
      DBG_PKT:   val_o = cnt_i[EVT_PKT];
      default:   val_o = '0;
    endcase
  end
endmodule

// File: rtl/modem_ctrl_regs.sv
module modem_ctrl_regs
  import modem_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned FBW_W  = 32,
  parameter int unsigned EQ_W   = 16,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned THR_W  = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned EQ_RST = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic              timing_lock_i,
  input  logic              freq_lock_i,
  input  logic              peak_evt_i,
  input  logic              hdr_fail_evt_i,
  input  logic              crc_err_evt_i,
  input  logic              pkt_ok_evt_i,
  input  logic [LEN_W-1:0]  payload_len_i,
  output logic [FBW_W-1:0]  loop_bw_o,
  output logic [EQ_W-1:0]   eq_step_inv_o,
  output logic [SEL_W-1:0]  scope_sel_o,
  output logic              eq_bypass_o,
  output logic              hdr_en_o,
  output logic [THR_W-1:0]  det_thr_o,
  output logic [THR_W-1:0]  det_thr_scaled_o,
  output logic              tx_one_o,
  output logic              tx_cont_o,
  output logic              loopback_o,
  output logic              coding_bypass_o
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr, wr_word, rd_word;
  logic [31:0]       wr_data, rd_data;
  logic [3:0]        wr_strb;

  logic [FBW_W-1:0] loop_bw_q;
  logic [EQ_W-1:0]  eq_step_q;
  logic [SEL_W-1:0] scope_q;
  logic [2:0]       dbg_sel_q;
  logic [THR_W-1:0] det_thr_q;
  logic eq_byp_q, hdr_en_q, tx_tgl_q, tx_cont_q, loopback_q, cod_byp_q, tx_one_q;

  logic [NUM_EVT-1:0]            evt_vec;
  logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt;
  logic [CNT_W-1:0]              dbg_val;

  modem_axil_if #(.ADDR_W(ADDR_W)) u_if (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bresp_o, .bvalid_o, .bready_i,
    .araddr_i, .arvalid_i, .arready_o,
    .rdata_o, .rresp_o, .rvalid_o, .rready_i,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  assign wr_word = wr_addr & WORD_MASK;
  assign rd_word = rd_addr & WORD_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loop_bw_q  <= '0;
      eq_step_q  <= EQ_W'(EQ_RST);
      scope_q    <= '0;
      dbg_sel_q  <= '0;
      det_thr_q  <= '0;
      eq_byp_q   <= 1'b0;
      hdr_en_q   <= 1'b1;
      tx_tgl_q   <= 1'b0;
      tx_cont_q  <= 1'b0;
      loopback_q <= 1'b0;
      cod_byp_q  <= 1'b0;
      tx_one_q   <= 1'b0;
    end else begin
      tx_one_q <= 1'b0;
      if (wr_en) begin
        if (wr_word == ADDR_W'(OFF_LOOP_BW))
          for (int b = 0; b < FBW_W; b++) if (wr_strb[b/8]) loop_bw_q[b] <= wr_data[b];
        if (wr_word == ADDR_W'(OFF_EQ_STEP))
          for (int b = 0; b < EQ_W; b++) if (wr_strb[b/8]) eq_step_q[b] <= wr_data[b];
        if (wr_word == ADDR_W'(OFF_DET_THR))
          for (int b = 0; b < THR_W; b++) if (wr_strb[b/8]) det_thr_q[b] <= wr_data[b];
        if (wr_strb[0]) begin
          if (wr_word == ADDR_W'(OFF_SCOPE))    scope_q    <= wr_data[SEL_W-1:0];
          if (wr_word == ADDR_W'(OFF_DBG_SEL))  dbg_sel_q  <= wr_data[2:0];
          if (wr_word == ADDR_W'(OFF_EQ_BYP))   eq_byp_q   <= wr_data[0];
          if (wr_word == ADDR_W'(OFF_HDR_EN))   hdr_en_q   <= wr_data[0];
          if (wr_word == ADDR_W'(OFF_TX_CONT))  tx_cont_q  <= wr_data[0];
          if (wr_word == ADDR_W'(OFF_LOOPBACK)) loopback_q <= wr_data[0];
          if (wr_word == ADDR_W'(OFF_COD_BYP))  cod_byp_q  <= wr_data[0];
          if (wr_word == ADDR_W'(OFF_TX_TGL)) begin
            tx_tgl_q <= wr_data[0];
            tx_one_q <= wr_data[0] != tx_tgl_q;
          end
        end
      end
    end
  end

  assign evt_vec[EVT_PEAK] = peak_evt_i;
  assign evt_vec[EVT_HDRF] = hdr_fail_evt_i;
  assign evt_vec[EVT_CRC]  = crc_err_evt_i;
  assign evt_vec[EVT_PKT]  = pkt_ok_evt_i;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    modem_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .evt_i(evt_vec[g]), .cnt_o(evt_cnt[g])
    );
  end

  modem_dbg_mux #(.CNT_W(CNT_W)) u_dbg (
    .tlock_i(timing_lock_i), .flock_i(freq_lock_i),
    .cnt_i(evt_cnt), .sel_i(dbg_sel_q), .val_o(dbg_val)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_word)
      ADDR_W'(OFF_LOOP_BW):  rd_data = 32'(loop_bw_q);
      ADDR_W'(OFF_EQ_STEP):  rd_data = 32'(eq_step_q);
      ADDR_W'(OFF_SCOPE):    rd_data = 32'(scope_q);
      ADDR_W'(OFF_DBG_SEL):  rd_data = 32'(dbg_sel_q);
      ADDR_W'(OFF_PLEN):     rd_data = 32'(payload_len_i);
      ADDR_W'(OFF_EQ_BYP):   rd_data = 32'(eq_byp_q);
      ADDR_W'(OFF_HDR_EN):   rd_data = 32'(hdr_en_q);
      ADDR_W'(OFF_DET_THR):  rd_data = 32'(det_thr_q);
      ADDR_W'(OFF_TX_TGL):   rd_data = 32'(tx_tgl_q);
      ADDR_W'(OFF_TX_CONT):  rd_data = 32'(tx_cont_q);
      ADDR_W'(OFF_LOOPBACK): rd_data = 32'(loopback_q);
      ADDR_W'(OFF_COD_BYP):  rd_data = 32'(cod_byp_q);
      ADDR_W'(OFF_DBG_VAL):  rd_data = 32'(dbg_val);
      default:               rd_data = '0;
    endcase
  end

  assign loop_bw_o        = loop_bw_q;
  assign eq_step_inv_o    = eq_step_q;
  assign scope_sel_o      = scope_q;
  assign eq_bypass_o      = eq_byp_q;
  assign hdr_en_o         = hdr_en_q;
  assign det_thr_o        = det_thr_q;
  assign det_thr_scaled_o = det_thr_q / THR_W'(10);
  assign tx_one_o         = tx_one_q;
  assign tx_cont_o        = tx_cont_q;
  assign loopback_o       = loopback_q;
  assign coding_bypass_o  = cod_byp_q;

  assert_tx_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_one_o |=> !tx_one_o);
  assert_tx_on_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_one_o |-> !$stable(tx_tgl_q));
  assert_tx_needs_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_tgl_q) |-> tx_one_o);
  assert_ro_untouched_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && (wr_word == ADDR_W'(OFF_PLEN)) |=> $stable(loop_bw_q) && $stable(eq_step_q)
      && $stable(det_thr_q) && $stable(tx_cont_q));
endmodule

// File: tb/sim_modem_ctrl_regs.sv
module sim_modem_ctrl_regs;
  typedef struct { logic [31:0] exp; string tag; } rd_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic tlock = 0, flock = 0, peak = 0, hdrf = 0, crc = 0, pkt = 0;
  logic [15:0] plen = '0;

  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata, loop_bw;
  logic [15:0] eq_step, det_thr, det_thr_s;
  logic [2:0] scope_sel;
  logic eq_byp, hdr_en, tx_one, tx_cont, loopback, cod_byp;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  rd_item_t sb[$];

  always #5 clk = ~clk;

  modem_ctrl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .awaddr_i(awaddr), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wvalid_i(wvalid), .wready_o(wready),
    .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(1'b1),
    .araddr_i(araddr), .arvalid_i(arvalid), .arready_o(arready),
    .rdata_o(rdata), .rresp_o(rresp), .rvalid_o(rvalid), .rready_i(1'b1),
    .timing_lock_i(tlock), .freq_lock_i(flock),
    .peak_evt_i(peak), .hdr_fail_evt_i(hdrf), .crc_err_evt_i(crc), .pkt_ok_evt_i(pkt),
    .payload_len_i(plen),
    .loop_bw_o(loop_bw), .eq_step_inv_o(eq_step), .scope_sel_o(scope_sel),
    .eq_bypass_o(eq_byp), .hdr_en_o(hdr_en), .det_thr_o(det_thr),
    .det_thr_scaled_o(det_thr_s), .tx_one_o(tx_one), .tx_cont_o(tx_cont),
    .loopback_o(loopback), .coding_bypass_o(cod_byp)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rvalid) begin
      if (sb.size() == 0) begin
        check(rdata, 32'hDEAD_BEEF, "R11 unexpected read response");
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        check(rdata, it.exp, it.tag);
        check(32'(rresp), 32'h0, "R11 rresp");
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #1;
    while (!awready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    check(32'(bvalid), 32'h1, "R11 bvalid");
    check(32'(bresp), 32'h0, "R11 bresp");
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    araddr = a; arvalid = 1;
    #1;
    while (!arready) @(negedge clk);
    sb.push_back('{exp: exp, tag: tag});
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    @(negedge clk);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check(32'(sb.size()), 32'h0, "R11 all reads answered");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(32'(eq_step), 32'd64, "R1 eq step reset");
    check(32'(hdr_en), 32'd1, "R1 header enable reset");
    check(loop_bw, 32'd0, "R1 loop bw reset");
    check({scope_sel, eq_byp, tx_one, tx_cont, loopback, cod_byp}, 32'd0, "R1 flags reset");
    rd(12'h104, 32'd64, "R1 read eq step");
    rd(12'h118, 32'd1, "R1 read header enable");
    rd(12'h11C, 32'd0, "R1 read threshold");

    // R2 write / readback
    wr(12'h100, 32'h1234_ABCD);
    check(loop_bw, 32'h1234_ABCD, "R2 loop bw port");
    rd(12'h100, 32'h1234_ABCD, "R2 loop bw read");
    wr(12'h108, 32'hFF);
    check(32'(scope_sel), 32'd7, "R2 scope port");
    rd(12'h108, 32'd7, "R2 scope truncated read");
    wr(12'h114, 32'h1); wr(12'h12C, 32'h1); wr(12'h130, 32'h1); wr(12'h118, 32'h0);
    check({eq_byp, loopback, cod_byp, hdr_en}, 32'b1110, "R2 flag ports");
    rd(12'h130, 32'd1, "R2 coding bypass read");
    rd(12'h118, 32'd0, "R2 header enable read");

    // R10 byte lanes
    wr(12'h104, 32'hAAAA_5555, 4'b0001);
    check(32'(eq_step), 32'h0055, "R10 lane 0 only");
    wr(12'h104, 32'h0000_1200, 4'b0010);
    rd(12'h104, 32'h1255, "R10 lane 1 merge");
    wr(12'h114, 32'h0, 4'b0010);
    check(32'(eq_byp), 32'd1, "R10 flag ignores lane 1");

    // R7 threshold scaling
    wr(12'h11C, 32'd1234);
    check(32'(det_thr_s), 32'd123, "R7 1234/10");
    rd(12'h11C, 32'd1234, "R7 raw threshold read");
    wr(12'h11C, 32'd9);
    check(32'(det_thr_s), 32'd0, "R7 9/10");
    wr(12'h11C, 32'hFFFF);
    check(32'(det_thr_s), 32'd6553, "R7 max/10");

    // R3 read-only length
    plen = 16'h05DC;
    rd(12'h110, 32'h05DC, "R3 payload length");
    wr(12'h110, 32'hFFFF_FFFF);
    rd(12'h110, 32'h05DC, "R3 write ignored");
    check(32'(det_thr), 32'hFFFF, "R3 threshold intact");

    // R4 unmapped
    rd(12'h128, 32'd0, "R4 hole read");
    rd(12'h200, 32'd0, "R4 far read");
    wr(12'h128, 32'hFFFF_FFFF);
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h100, 32'h1234_ABCD, "R4 loop bw intact");
    check({tx_cont, tx_one}, 32'd0, "R4 tx intact");

    // R5 toggle trigger
    wr(12'h120, 32'h1);
    check(32'(tx_one), 32'd1, "R5 pulse on 0->1");
    @(negedge clk);
    check(32'(tx_one), 32'd0, "R5 pulse one cycle");
    wr(12'h120, 32'h1);
    check(32'(tx_one), 32'd0, "R5 same value no pulse");
    rd(12'h120, 32'd1, "R5 toggle readback");
    wr(12'h120, 32'h0);
    check(32'(tx_one), 32'd1, "R5 pulse on 1->0");
    @(negedge clk);
    check(32'(tx_one), 32'd0, "R5 pulse cleared");
    wr(12'h120, 32'h2);
    check(32'(tx_one), 32'd0, "R5 bit1 no pulse");

    // R6 continuous
    wr(12'h124, 32'h1);
    check(32'(tx_cont), 32'd1, "R6 continuous on");
    rd(12'h124, 32'd1, "R6 readback");
    wr(12'h124, 32'h0);
    check(32'(tx_cont), 32'd0, "R6 continuous off");

    // R8 lock levels
    tlock = 1;
    wr(12'h10C, 32'd0);
    rd(12'h140, 32'd1, "R8 timing lock high");
    tlock = 0;
    rd(12'h140, 32'd0, "R8 timing lock live low");
    flock = 1;
    wr(12'h10C, 32'd1);
    rd(12'h140, 32'd1, "R8 freq lock");

    // R9 event counts through R8 selection
    peak = 1; repeat (5) @(negedge clk); peak = 0;
    hdrf = 1; repeat (3) @(negedge clk); hdrf = 0;
    crc = 1;  repeat (2) @(negedge clk); crc = 0;
    pkt = 1;  repeat (7) @(negedge clk); pkt = 0;
    wr(12'h10C, 32'd2); rd(12'h140, 32'd5, "R9 peak count");
    wr(12'h10C, 32'd3); rd(12'h140, 32'd3, "R9 header fail count");
    wr(12'h10C, 32'd4); rd(12'h140, 32'd2, "R9 crc count");
    wr(12'h10C, 32'd5); rd(12'h140, 32'd7, "R9 packet count");
    wr(12'h10C, 32'd6); rd(12'h140, 32'd0, "R8 code 6 zero");
    wr(12'h10C, 32'd7); rd(12'h140, 32'd0, "R8 code 7 zero");

    // R9 saturation
    peak = 1; repeat (65540) @(negedge clk); peak = 0;
    wr(12'h10C, 32'd2); rd(12'h140, 32'hFFFF, "R9 saturated");
    wr(12'h10C, 32'd3); rd(12'h140, 32'd3, "R9 neighbour unaffected");

    drain();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule